// File: doc/BRIEF.md
# Serial-Peripheral Memory Slave Engine

This block is the serial front end of a byte-wide memory. It runs on a fast system clock and watches an SPI mode 0 link on four input pins: serial clock, active-low select, active-low pause, and serial data in. It samples serial input on rising serial clock and updates serial output on falling serial clock, with the most significant bit first. Each selection starts with an 8-bit command. The engine then collects a 16-bit byte address or a data byte, or it streams data back.

On its inner side the engine drives a synchronous byte-wide array port with one cycle of read latency. It also drives a status/protection unit through single-cycle strobes. That unit holds the write-enable latch, the status byte and the busy flag. The engine only decodes commands and moves bytes. Protection policy and write timing belong to the neighbouring unit. The output driver is modelled as a data bit plus an output-enable.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset, so_oe is low and no strobe (wen_set, wen_clr, sr_we, mem_we) is asserted.
- R2: Command bytes are decoded with bit 3 ignored and bits 7..4 required to be zero. Low bits 110 pulse wen_set, 100 pulses wen_clr, 101 selects status read, 001 selects status write, 011 selects array read, and 010 selects array write.
- R3: A command byte that is not recognised makes the engine ignore all further serial input and keep so_oe low until the select goes high and falls again.
- R4: Status read drives status_rdata on so, most significant bit first, starting at the falling clock after the eighth command bit. The byte repeats for as long as clocking continues.
- R5: Array read takes a 16-bit address, most significant byte first, and uses only its low 13 bits. It then streams the addressed byte, most significant bit first, with so_oe high.
- R6: During an array read the address advances by one after each byte and wraps from 0x1FFF to 0x0000.
- R7: While hold_n is low, so_oe is low and serial clock edges are ignored. Bit position, address and output data are preserved across the pause.
- R8: While cs_n is high, so_oe is low and serial input has no effect. A rising cs_n discards any partial byte, and the next command starts from bit 7.
- R9: Status write passes the byte that follows the command to sr_wdata with a single sr_we pulse. Later bytes are ignored.
- R10: Array write takes a 16-bit address and then emits one mem_we pulse per data byte. The address advances within a 32-byte page: the low 5 bits wrap and the upper bits are kept.
- R11: While busy is high, every command except status read is treated as unrecognised.
- R12: Strobes to the status unit and the array last one clock each, and at most one of them is high in any clock.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the serial link |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low select |
| hold_n | input | 1 | Active-low pause |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out bit |
| so_oe | output | 1 | Output enable for so |
| mem_addr | output | 13 | Array byte address |
| mem_re | output | 1 | Array read request, data one clock later |
| mem_we | output | 1 | Array write strobe |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data |
| status_rdata | input | 8 | Status byte from the protection unit |
| busy | input | 1 | Internal write cycle in progress |
| wen_set | output | 1 | Set write-enable latch |
| wen_clr | output | 1 | Clear write-enable latch |
| sr_we | output | 1 | Status write strobe |
| sr_wdata | output | 8 | Status write data |

## Verification
All pins pass through two synchroniser stages and one edge register. A strobe for a completed byte therefore appears three clocks after the eighth rising serial clock, and a new so bit appears three clocks after a falling serial clock. so_oe follows a change on cs_n or hold_n after two clocks. The bench keeps each serial clock phase for eight system clocks and samples so and so_oe at the end of the low phase, well after any of these delays. Strobes are collected every clock and compared with the expected event list after each deselect.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

   typedef enum logic [2:0] {
      PH_OPC, PH_ADDR, PH_WDATA, PH_SRDATA, PH_OUT, PH_LOCK
   } phase_e;

   typedef enum logic [2:0] {
      CMD_NONE, CMD_WREN, CMD_WRDI, CMD_RDSR, CMD_WRSR, CMD_READ, CMD_WRITE
   } cmd_e;

   // upper nibble must be zero; bit 3 is never passed in
   function automatic cmd_e op_decode(input logic [3:0] hi, input logic [2:0] lo);
      if (hi != 4'h0) return CMD_NONE;
      case (lo)
         3'b110:  return CMD_WREN;
         3'b100:  return CMD_WRDI;
         3'b101:  return CMD_RDSR;
         3'b001:  return CMD_WRSR;
         3'b011:  return CMD_READ;
         3'b010:  return CMD_WRITE;
         default: return CMD_NONE;
      endcase
   endfunction

endpackage

// File: rtl/spi_mem_sync.sv
module spi_mem_sync #(
   parameter int          W      = 4,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] INIT  = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [STAGES-1:0][W-1:0] st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= {STAGES{INIT}};
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/spi_mem_tx.sv
module spi_mem_tx #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic [BYTE_W-1:0] din,
   output logic              bit_o
);

   logic [BYTE_W-1:0] rest;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_o <= 1'b0;
         rest  <= '0;
      end else if (load) begin
         bit_o <= din[BYTE_W-1];
         rest  <= {din[BYTE_W-2:0], 1'b0};
      end else if (step) begin
         bit_o <= rest[BYTE_W-1];
         rest  <= {rest[BYTE_W-2:0], 1'b0};
      end
   end

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
   import spi_mem_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter int ADDR_BYTES  = 2,
   parameter int PAGE_BITS   = 5,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck,
   input  logic              cs_n,
   input  logic              hold_n,
   input  logic              si,
   output logic              so,
   output logic              so_oe,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   input  logic [7:0]        status_rdata,
   input  logic              busy,
   output logic              wen_set,
   output logic              wen_clr,
   output logic              sr_we,
   output logic [7:0]        sr_wdata
);

   localparam int BYTE_W = 8;
   localparam int HI_W   = ADDR_W - BYTE_W;
   localparam int ACNT_W = (ADDR_BYTES > 2) ? $clog2(ADDR_BYTES) : 1;

   generate
      if (ADDR_W <= BYTE_W || ADDR_W > BYTE_W * ADDR_BYTES) begin : g_bad_addr
         $error("ADDR_W must exceed one byte and fit in ADDR_BYTES");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (PAGE_BITS < 1 || PAGE_BITS > ADDR_W) begin : g_bad_page
         $error("PAGE_BITS out of range");
      end
   endgenerate

   // ---------------- pin synchronisation and edges ----------------
   logic sck_s, cs_s, hold_s, si_s, sck_q, cs_q;

   spi_mem_sync #(.W(4), .STAGES(SYNC_STAGES), .INIT(4'b0110)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({sck, cs_n, hold_n, si}),
      .q({sck_s, cs_s, hold_s, si_s})
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_s;
      end
   end

   logic live, sck_rise, sck_fall, cs_edge;
   assign live     = !cs_s && hold_s;
   assign sck_rise = live && sck_s && !sck_q;
   assign sck_fall = live && !sck_s && sck_q;
   assign cs_edge  = cs_s ^ cs_q;

   // ---------------- state ----------------
   phase_e             phase;
   cmd_e               cmd, op_cmd;
   logic [2:0]         bcnt, ocnt;
   logic [6:0]         sh_in;
   logic [ACNT_W-1:0]  acnt;
   logic [HI_W-1:0]    addr_sh;
   logic [ADDR_W-1:0]  waddr, waddr_inc, a_next;
   logic [7:0]         nb, rbuf;
   logic               drv, rd_pend, shifting, byte_done;

   assign nb        = {sh_in, si_s};
   assign a_next    = {addr_sh, nb};
   assign shifting  = (phase == PH_OPC) || (phase == PH_ADDR) ||
                      (phase == PH_WDATA) || (phase == PH_SRDATA);
   assign byte_done = sck_rise && shifting && (bcnt == 3'd7);

   always_comb begin
      op_cmd = op_decode(nb[7:4], nb[2:0]);
      if (busy && op_cmd != CMD_RDSR) op_cmd = CMD_NONE;
   end

   generate
      if (PAGE_BITS >= ADDR_W) begin : g_flat
         assign waddr_inc = waddr + 1'b1;
      end else begin : g_page
         assign waddr_inc = {waddr[ADDR_W-1:PAGE_BITS], waddr[PAGE_BITS-1:0] + 1'b1};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_OPC;
         cmd       <= CMD_NONE;
         bcnt      <= '0;
         ocnt      <= '0;
         sh_in     <= '0;
         acnt      <= '0;
         addr_sh   <= '0;
         waddr     <= '0;
         rbuf      <= '0;
         drv       <= 1'b0;
         rd_pend   <= 1'b0;
         mem_addr  <= '0;
         mem_re    <= 1'b0;
         mem_we    <= 1'b0;
         mem_wdata <= '0;
         wen_set   <= 1'b0;
         wen_clr   <= 1'b0;
         sr_we     <= 1'b0;
         sr_wdata  <= '0;
      end else begin
         mem_re  <= 1'b0;
         mem_we  <= 1'b0;
         wen_set <= 1'b0;
         wen_clr <= 1'b0;
         sr_we   <= 1'b0;
         rd_pend <= mem_re;
         if (rd_pend) rbuf <= mem_rdata;

         if (cs_edge) begin
            phase <= PH_OPC;
            bcnt  <= '0;
            ocnt  <= '0;
            acnt  <= '0;
            drv   <= 1'b0;
         end else begin
            if (sck_rise && shifting) begin
               sh_in <= nb[6:0];
               bcnt  <= bcnt + 3'd1;
            end
            if (byte_done) begin
               unique case (phase)
                  PH_OPC: begin
                     cmd <= op_cmd;
                     unique case (op_cmd)
                        CMD_WREN:  begin wen_set <= 1'b1; phase <= PH_LOCK; end
                        CMD_WRDI:  begin wen_clr <= 1'b1; phase <= PH_LOCK; end
                        CMD_RDSR:  phase <= PH_OUT;
                        CMD_WRSR:  phase <= PH_SRDATA;
                        CMD_READ,
                        CMD_WRITE: begin phase <= PH_ADDR; acnt <= '0; end
                        default:   phase <= PH_LOCK;
                     endcase
                  end
                  PH_ADDR: begin
                     addr_sh <= HI_W'({addr_sh, nb});
                     acnt    <= acnt + 1'b1;
                     if (acnt == ACNT_W'(ADDR_BYTES - 1)) begin
                        if (cmd == CMD_READ) begin
                           mem_addr <= a_next;
                           mem_re   <= 1'b1;
                           phase    <= PH_OUT;
                        end else begin
                           waddr <= a_next;
                           phase <= PH_WDATA;
                        end
                     end
                  end
                  PH_WDATA: begin
                     mem_we    <= 1'b1;
                     mem_addr  <= waddr;
                     mem_wdata <= nb;
                     waddr     <= waddr_inc;
                  end
                  PH_SRDATA: begin
                     sr_we    <= 1'b1;
                     sr_wdata <= nb;
                     phase    <= PH_LOCK;
                  end
                  default: ;
               endcase
            end
            if (sck_fall && phase == PH_OUT) begin
               drv  <= 1'b1;
               ocnt <= ocnt + 3'd1;
               if (ocnt == 3'd0 && cmd == CMD_READ) begin
                  mem_addr <= mem_addr + 1'b1;
                  mem_re   <= 1'b1;
               end
            end
         end
      end
   end

   // ---------------- output shifter ----------------
   logic tx_load, tx_step;
   assign tx_load = sck_fall && (phase == PH_OUT) && (ocnt == 3'd0);
   assign tx_step = sck_fall && (phase == PH_OUT) && (ocnt != 3'd0);

   spi_mem_tx #(.BYTE_W(BYTE_W)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .load(tx_load), .step(tx_step),
      .din((cmd == CMD_RDSR) ? status_rdata : rbuf),
      .bit_o(so)
   );

   assign so_oe = drv && (phase == PH_OUT) && live;

endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk
   import spi_mem_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   cs_s,
   input logic   hold_s,
   input logic   so_oe,
   input phase_e phase,
   input logic   mem_re,
   input logic   mem_we,
   input logic   wen_set,
   input logic   wen_clr,
   input logic   sr_we
);

   p_cs_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |-> !so_oe);

   p_hold_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !hold_s |-> !so_oe);

   p_lock_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_LOCK) |-> !so_oe);

   p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_we, wen_set, wen_clr, sr_we}));

   p_re_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> !mem_re);

   p_we_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !mem_we);

endmodule

bind spi_mem_slave spi_mem_slave_chk u_chk (.*);

// File: tb/spi_mem_slave_tb.sv
module spi_mem_slave_tb_top;

   localparam int HALF = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sck = 1'b0, cs_n = 1'b1, hold_n = 1'b1, si = 1'b0, busy = 1'b0;
   logic [7:0]  status_rdata = 8'h00;
   logic [7:0]  mem_rdata = 8'h00;
   logic        so, so_oe, mem_re, mem_we, wen_set, wen_clr, sr_we;
   logic [12:0] mem_addr;
   logic [7:0]  mem_wdata, sr_wdata;

   always #2.5 clk = ~clk;

   spi_mem_slave dut_i (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .hold_n(hold_n), .si(si),
      .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_re(mem_re), .mem_we(mem_we),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .status_rdata(status_rdata),
      .busy(busy), .wen_set(wen_set), .wen_clr(wen_clr), .sr_we(sr_we), .sr_wdata(sr_wdata)
   );

   int checks = 0, errors = 0;
   bit finished = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // ---------- behavioural array ----------
   logic [7:0] store [int];
   function automatic logic [7:0] mv(input int a);
      int k = a & 32'h1FFF;
      if (store.exists(k)) return store[k];
      return 8'((k * 7 + 3) ^ (k >> 8));
   endfunction

   always @(posedge clk) begin
      if (mem_re) mem_rdata <= mv(int'(mem_addr));
      if (mem_we) store[int'(mem_addr)] = mem_wdata;
   end

   // ---------- every-clock monitor ----------
   typedef struct { int k; int a; int d; } ev_t;
   ev_t got_q[$], exp_q[$];
   logic [3:0] prev_strb = 4'h0;
   int strobe_bad = 0, oe_bad = 0;
   bit oe_ok = 0;

   always @(negedge clk) begin
      logic [3:0] s;
      s = {mem_we, sr_we, wen_clr, wen_set};
      if (rst_n) begin
         if ($countones(s) > 1 || (s & prev_strb) != 4'h0) strobe_bad++;
         if (so_oe && !oe_ok) oe_bad++;
         if (wen_set) got_q.push_back('{1, 0, 0});
         if (wen_clr) got_q.push_back('{2, 0, 0});
         if (sr_we)   got_q.push_back('{3, 0, int'(sr_wdata)});
         if (mem_we)  got_q.push_back('{4, int'(mem_addr), int'(mem_wdata)});
      end
      prev_strb = s;
   end

   task automatic push_exp(input int k, input int a, input int d);
      exp_q.push_back('{k, a, d});
   endtask

   task automatic ev_cmp(input string tag);
      chk(tag, got_q.size(), exp_q.size());
      if (got_q.size() == exp_q.size())
         foreach (exp_q[i])
            chk(tag, {got_q[i].k[7:0], got_q[i].a[15:0], got_q[i].d[7:0]},
                     {exp_q[i].k[7:0], exp_q[i].a[15:0], exp_q[i].d[7:0]});
      got_q.delete();
      exp_q.delete();
   endtask

   // ---------- serial driver ----------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_io(input logic b, output logic r, output logic oe);
      si = b;
      tick(HALF);
      r  = so;
      oe = so_oe;
      sck = 1'b1;
      tick(HALF);
      sck = 1'b0;
   endtask

   task automatic byte_io(input logic [7:0] tx, output logic [7:0] rx, output logic oe_all);
      logic r, oe;
      oe_all = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         bit_io(tx[i], r, oe);
         rx[i]  = r;
         oe_all = oe_all & oe;
      end
   endtask

   task automatic cs_on();
      cs_n = 1'b0;
      tick(HALF);
   endtask

   task automatic cs_off();
      tick(HALF);
      cs_n = 1'b1;
      tick(4);
      oe_ok = 0;
      tick(2 * HALF);
   endtask

   task automatic run_read(input string tag, input logic [15:0] addr, input int n);
      logic [7:0] rx;
      logic oe;
      cs_on();
      byte_io(8'h03, rx, oe);
      byte_io(addr[15:8], rx, oe);
      byte_io(addr[7:0], rx, oe);
      oe_ok = 1;
      for (int i = 0; i < n; i++) begin
         byte_io(8'h5A, rx, oe);
         chk(tag, rx, mv(int'(addr) + i));
         chk(tag, oe, 1'b1);
      end
      cs_off();
   endtask

   // ---------- watchdog ----------
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   // ---------- scenarios ----------
   initial begin
      logic [7:0] rx, acc;
      logic oe, r;
      tick(5);
      rst_n = 1'b1;
      tick(10);

      // R1: quiet after reset
      chk("R1 so_oe", so_oe, 1'b0);
      ev_cmp("R1 strobes");

      // R2: write enable set, with and without bit 3; clear
      cs_on(); byte_io(8'h06, rx, oe); cs_off();
      push_exp(1, 0, 0); ev_cmp("R2 set 06");
      cs_on(); byte_io(8'h0E, rx, oe); cs_off();
      push_exp(1, 0, 0); ev_cmp("R2 set 0E");
      cs_on(); byte_io(8'h04, rx, oe); cs_off();
      push_exp(2, 0, 0); ev_cmp("R2 clear 04");

      // R4: status read repeats
      status_rdata = 8'hA5;
      cs_on(); byte_io(8'h05, rx, oe); oe_ok = 1;
      byte_io(8'h00, rx, oe); chk("R4 byte0", rx, 8'hA5); chk("R4 oe", oe, 1'b1);
      byte_io(8'hFF, rx, oe); chk("R4 byte1", rx, 8'hA5);
      cs_off();
      status_rdata = 8'h3C;
      cs_on(); byte_io(8'h0D, rx, oe); oe_ok = 1;
      byte_io(8'h00, rx, oe); chk("R4 bit3 ignored", rx, 8'h3C);
      cs_off();
      ev_cmp("R4 no strobes");

      // R5: upper address bits ignored
      run_read("R5 read", 16'hE010, 3);
      // R6: wrap at top of array
      run_read("R6 wrap", 16'hFFFE, 3);

      // R10: page write with low-bit wrap
      cs_on();
      byte_io(8'h02, rx, oe); byte_io(8'hF0, rx, oe); byte_io(8'h1E, rx, oe);
      byte_io(8'h11, rx, oe); byte_io(8'h22, rx, oe); byte_io(8'h33, rx, oe);
      chk("R10 oe low", oe, 1'b0);
      cs_off();
      push_exp(4, 16'h101E, 8'h11); push_exp(4, 16'h101F, 8'h22); push_exp(4, 16'h1000, 8'h33);
      ev_cmp("R10 writes");
      run_read("R10 readback", 16'h101E, 2);
      run_read("R10 readback wrap", 16'h1000, 1);

      // R9: status write, trailing byte ignored
      cs_on(); byte_io(8'h01, rx, oe); byte_io(8'h8C, rx, oe); byte_io(8'h55, rx, oe); cs_off();
      push_exp(3, 0, 8'h8C); ev_cmp("R9 status write");

      // R3: invalid commands lock out until reselect
      cs_on(); byte_io(8'h85, rx, oe); byte_io(8'h06, rx, oe); byte_io(8'h05, rx, oe);
      chk("R3 oe low", oe, 1'b0); cs_off();
      cs_on(); byte_io(8'h07, rx, oe); byte_io(8'h04, rx, oe); cs_off();
      ev_cmp("R3 no strobes");
      cs_on(); byte_io(8'h06, rx, oe); cs_off();
      push_exp(1, 0, 0); ev_cmp("R3 next select decodes");

      // R11: busy blocks all but status read
      busy = 1'b1;
      cs_on(); byte_io(8'h06, rx, oe); cs_off();
      cs_on(); byte_io(8'h02, rx, oe); byte_io(8'h00, rx, oe); byte_io(8'h00, rx, oe);
      byte_io(8'h77, rx, oe); cs_off();
      ev_cmp("R11 busy blocks");
      status_rdata = 8'hFF;
      cs_on(); byte_io(8'h05, rx, oe); oe_ok = 1;
      byte_io(8'h00, rx, oe); chk("R11 status while busy", rx, 8'hFF);
      cs_off();
      busy = 1'b0;

      // R7: pause in address and in data
      cs_on();
      byte_io(8'h03, rx, oe); byte_io(8'h00, rx, oe);
      bit_io(1'b1, r, oe);
      for (int i = 0; i < 3; i++) bit_io(1'b0, r, oe);
      tick(4); hold_n = 1'b0; tick(HALF);
      for (int i = 0; i < 2; i++) begin si = 1'b1; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF); end
      hold_n = 1'b1; tick(4);
      for (int i = 0; i < 4; i++) bit_io(1'b0, r, oe);
      oe_ok = 1;
      acc = 8'h00;
      for (int i = 7; i >= 5; i--) begin bit_io(1'b0, r, oe); acc[i] = r; end
      tick(4); hold_n = 1'b0; tick(HALF);
      chk("R7 oe low in pause", so_oe, 1'b0);
      for (int i = 0; i < 3; i++) begin si = 1'b1; sck = 1'b1; tick(HALF); sck = 1'b0; tick(HALF); end
      chk("R7 oe still low", so_oe, 1'b0);
      hold_n = 1'b1; tick(4);
      for (int i = 4; i >= 0; i--) begin bit_io(1'b0, r, oe); acc[i] = r; end
      chk("R7 oe after release", oe, 1'b1);
      chk("R7 byte intact", acc, mv(16'h0080));
      byte_io(8'h00, rx, oe); chk("R7 next byte", rx, mv(16'h0081));
      cs_off();
      ev_cmp("R7 no strobes");

      // R8: partial byte discarded, deselected clocks ignored
      cs_on();
      for (int i = 0; i < 4; i++) bit_io(1'b0, r, oe);
      bit_io(1'b1, r, oe); bit_io(1'b1, r, oe);
      cs_off();
      for (int i = 0; i < 16; i++) bit_io(1'b1, r, oe);
      chk("R8 oe deselected", oe, 1'b0);
      ev_cmp("R8 no strobes deselected");
      cs_on(); byte_io(8'h06, rx, oe); cs_off();
      push_exp(1, 0, 0); ev_cmp("R8 fresh command");

      // R12 and R8 every-clock monitors
      chk("R12 strobe shape", strobe_bad, 0);
      chk("R8 oe only in data phase", oe_bad, 0);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule